// File: doc/BRIEF.md
# Marker-Based Multi-Link Sample Aligner

This block lines up several parallel sample streams coming from converters whose pipeline latencies differ. Each stream carries an extra flag bit beside every sample word. The flag is set on exactly one sample, the one taken at the instant of a shared timing pulse. The block watches for these flagged samples. It measures how many cycles each link trails the earliest one. It then delays every link by the difference, so that the flagged samples of all links leave the block in the same cycle. No frame or multiframe clock is involved, so the result does not depend on how much latency each converter adds.

Measurement starts on the first flagged sample seen on any link. Every other link must deliver its flagged sample within a window of `MAX_SKEW` cycles. If one does not, an error flag is raised and the block waits for the next flagged sample. Once the block is locked, later flags normally pass straight through. They start a new measurement only while the realign input is high.

Each link has a shift register `MAX_SKEW` entries deep. A per-link tap on it sets the delay. The flag and valid bits travel with the data through the same path.

Top module: `ts_sample_aligner`

## Requirements
- R1: After reset, `aligned`, `skew_err` and all bits of `out_valid` are low.
- R2: A sample counts as a marker only when both its `in_mark` bit and its `in_valid` bit are high. A mark bit on an invalid sample starts no measurement. On the output it appears with `out_mark` low.
- R3: When the last link's marker arrives in cycle T, `aligned` is high from cycle T+1. The marked samples of all links appear together on `out_mark`/`out_data` in cycle T+2.
- R4: While `aligned` is high, every link outputs the sample that had the same position relative to its own marker. Data, mark and valid bits are carried unchanged through the delay.
- R5: A link whose marker trails the first marker by up to `MAX_SKEW-1` cycles is aligned without error.
- R6: If any link gives no marker within `MAX_SKEW-1` cycles of the first marker, `skew_err` goes high and `aligned` stays low. `skew_err` clears on the next successful lock.
- R7: While locked with `realign_en` low, new markers leave `aligned` high and leave the link delays unchanged.
- R8: While locked with `realign_en` high, a marker on only some links starts a new measurement, and `aligned` falls in the next cycle.
- R9: Markers arriving on all links in the same cycle give an immediate lock with equal delays on every link.
- R10: `aligned` and `skew_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| realign_en | input | 1 | Allows a marker seen while locked to restart measurement |
| in_valid | input | NLINKS | Per-link sample valid |
| in_mark | input | NLINKS | Per-link timing flag bit |
| in_data | input | NLINKS*DW | Per-link sample words, link i in bits i*DW upward |
| out_valid | output | NLINKS | Delayed valid per link |
| out_mark | output | NLINKS | Delayed marker per link |
| out_data | output | NLINKS*DW | Delayed sample words |
| aligned | output | 1 | Delays are set from a complete measurement |
| skew_err | output | 1 | Last measurement exceeded the skew window |

## Verification
The hardest case to reach is a re-measurement triggered while the block is already locked. Old delays are still shaping the outputs at that point, and the new skews differ from the old ones. The stimulus locks on one skew pattern and first sends a lone marker with `realign_en` low, which must be ignored. It then switches every link to a new skew pattern with `realign_en` high, and the scoreboard checks that the new markers come out together. A window test places one link at exactly `MAX_SKEW-1` cycles late, and then at one cycle beyond that.

// File: rtl/ts_sample_aligner.sv
module ts_sample_aligner #(
  parameter int NLINKS   = 4,
  parameter int DW       = 16,
  parameter int MAX_SKEW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 realign_en,
  input  logic [NLINKS-1:0]    in_valid,
  input  logic [NLINKS-1:0]    in_mark,
  input  logic [NLINKS*DW-1:0] in_data,
  output logic [NLINKS-1:0]    out_valid,
  output logic [NLINKS-1:0]    out_mark,
  output logic [NLINKS*DW-1:0] out_data,
  output logic                 aligned,
  output logic                 skew_err
);
  localparam int OW = $clog2(MAX_SKEW);
  localparam int CW = $clog2(MAX_SKEW + 1);
  localparam int EW = DW + 2;

  typedef enum logic [1:0] {S_HUNT, S_MEAS, S_LOCK} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [NLINKS-1:0] seen, seen_eff, mk;
  logic [OW-1:0]    off   [NLINKS];
  logic [OW-1:0]    eff   [NLINKS];
  logic [OW-1:0]    d_new [NLINKS];
  logic [OW-1:0]    dly   [NLINKS];
  logic [OW-1:0]    maxo;
  logic             start, all_in, timeout;

  assign mk      = in_valid & in_mark;
  assign start   = |mk && (st == S_HUNT || (st == S_LOCK && realign_en));
  assign aligned = (st == S_LOCK);

  always_comb begin
    seen_eff = start ? mk : (seen | mk);
    maxo = '0;
    for (int i = 0; i < NLINKS; i++) begin
      eff[i] = start ? '0 : (seen[i] ? off[i] : cnt[OW-1:0]);
      if (eff[i] > maxo) maxo = eff[i];
    end
    for (int i = 0; i < NLINKS; i++) d_new[i] = maxo - eff[i];
  end

  assign all_in  = &seen_eff;
  assign timeout = (st == S_MEAS) && !all_in && (cnt == CW'(MAX_SKEW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_HUNT;
      cnt      <= '0;
      seen     <= '0;
      skew_err <= 1'b0;
      for (int i = 0; i < NLINKS; i++) begin
        off[i] <= '0;
        dly[i] <= '0;
      end
    end else if ((start || st == S_MEAS) && all_in) begin
      st       <= S_LOCK;
      skew_err <= 1'b0;
      seen     <= '0;
      for (int i = 0; i < NLINKS; i++) dly[i] <= d_new[i];
    end else if (start) begin
      st   <= S_MEAS;
      seen <= mk;
      cnt  <= CW'(1);
      for (int i = 0; i < NLINKS; i++) off[i] <= '0;
    end else if (timeout) begin
      st       <= S_HUNT;
      skew_err <= 1'b1;
      seen     <= '0;
    end else if (st == S_MEAS) begin
      seen <= seen | mk;
      cnt  <= cnt + CW'(1);
      for (int i = 0; i < NLINKS; i++)
        if (mk[i] && !seen[i]) off[i] <= cnt[OW-1:0];
    end
  end

  for (genvar g = 0; g < NLINKS; g++) begin : g_link
    logic [EW-1:0] sh [MAX_SKEW];
    logic [EW-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < MAX_SKEW; k++) sh[k] <= '0;
        q <= '0;
      end else begin
        sh[0] <= {in_valid[g], mk[g], in_data[g*DW +: DW]};
        for (int k = 1; k < MAX_SKEW; k++) sh[k] <= sh[k-1];
        q <= sh[dly[g]];
      end
    end

    assign out_valid[g]         = q[EW-1];
    assign out_mark[g]          = q[EW-2];
    assign out_data[g*DW +: DW] = q[DW-1:0];
  end
endmodule

module ts_aligner_chk #(
  parameter int NLINKS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              realign_en,
  input logic [NLINKS-1:0] in_valid,
  input logic [NLINKS-1:0] in_mark,
  input logic [NLINKS-1:0] out_valid,
  input logic [NLINKS-1:0] out_mark,
  input logic              aligned,
  input logic              skew_err
);
  // R10
  no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(aligned && skew_err));

  // R3
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned) |-> $past(|(in_valid & in_mark)));

  // R7
  hold_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && !realign_en) |=> aligned);

  // R6
  err_from_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(skew_err) |-> !$past(aligned));

  // R2
  mark_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mark & ~out_valid) == '0);

  // R8
  realign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned && realign_en && |(in_valid & in_mark) && !(&(in_valid & in_mark)))
      |=> !aligned);
endmodule

bind ts_sample_aligner ts_aligner_chk #(.NLINKS(NLINKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .realign_en(realign_en),
  .in_valid(in_valid), .in_mark(in_mark),
  .out_valid(out_valid), .out_mark(out_mark),
  .aligned(aligned), .skew_err(skew_err)
);

// File: tb/tb_ts_sample_aligner.sv
`timescale 1ns/1ps
module tb_ts_sample_aligner;
  localparam int NL = 4;
  localparam int DW = 16;
  localparam int MS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic realign_en = 1'b0;
  logic [NL-1:0]    in_valid = '0;
  logic [NL-1:0]    in_mark = '0;
  logic [NL*DW-1:0] in_data = '0;
  logic [NL-1:0]    out_valid, out_mark;
  logic [NL*DW-1:0] out_data;
  logic aligned, skew_err;

  ts_sample_aligner #(.NLINKS(NL), .DW(DW), .MAX_SKEW(MS)) dut (
    .clk(clk), .rst_n(rst_n), .realign_en(realign_en),
    .in_valid(in_valid), .in_mark(in_mark), .in_data(in_data),
    .out_valid(out_valid), .out_mark(out_mark), .out_data(out_data),
    .aligned(aligned), .skew_err(skew_err));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int offs [NL] = '{0, 0, 0, 0};
  logic [NL-1:0] mask = '0;
  logic vld = 1'b0;
  int mpos = 1000;
  int exp_q[$];
  logic chk_cont = 1'b0;
  logic [NL-1:0] last_partial = '0;
  logic saw_drop = 1'b0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire(input int o0, input int o1, input int o2, input int o3,
                      input logic [NL-1:0] m, input logic expect_lock);
    offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3;
    mask = m;
    mpos = cyc + 10;
    if (expect_lock) exp_q.push_back(mpos & 12'hfff);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!aligned) saw_drop <= 1'b1;
      if (aligned && chk_cont && &out_valid)
        for (int i = 1; i < NL; i++)
          check(out_data[i*DW +: 12] == out_data[11:0], "R4",
                int'(out_data[i*DW +: 12]), int'(out_data[11:0]));
      if (aligned && |out_mark) begin
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check(&out_mark, "R3", int'(out_mark), (1 << NL) - 1);
          for (int i = 0; i < NL; i++)
            check(int'(out_data[i*DW +: 12]) == e, "R3",
                  int'(out_data[i*DW +: 12]), e);
        end else begin
          last_partial <= out_mark;
        end
      end
    end
    for (int i = 0; i < NL; i++) begin
      logic [11:0] s;
      s = 12'(cyc - offs[i]);
      in_data[i*DW +: DW] = {4'(i), s};
      in_mark[i]  = mask[i] && ((cyc - offs[i]) == mpos);
      in_valid[i] = vld;
    end
  end

  initial begin
    wait_cyc(5);
    #1;
    check(!aligned && !skew_err && out_valid == '0, "R1",
          int'({aligned, skew_err, out_valid}), 0);
    rst_n = 1'b1;

    fire(0, 0, 0, 0, 4'hf, 1'b0);
    wait_cyc(20);
    #1;
    check(!aligned && !skew_err, "R2", int'({aligned, skew_err}), 0);
    check(out_mark == '0, "R2", int'(out_mark), 0);

    vld = 1'b1;
    fire(0, 3, 1, 5, 4'hf, 1'b1);
    wait_cyc(25);
    #1;
    check(aligned && !skew_err, "R3", int'({aligned, skew_err}), 2);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    chk_cont = 1'b1;
    wait_cyc(10);

    last_partial = '0;
    realign_en = 1'b0;
    fire(0, 3, 1, 5, 4'h1, 1'b0);
    wait_cyc(25);
    #1;
    check(aligned, "R7", int'(aligned), 1);
    check(last_partial == 4'h1, "R7", int'(last_partial), 1);

    chk_cont = 1'b0;
    saw_drop = 1'b0;
    realign_en = 1'b1;
    fire(2, 0, 4, 1, 4'hf, 1'b1);
    wait_cyc(25);
    #1;
    check(saw_drop, "R8", int'(saw_drop), 1);
    check(aligned && exp_q.size() == 0, "R8", exp_q.size(), 0);
    chk_cont = 1'b1;
    wait_cyc(10);
    chk_cont = 1'b0;

    fire(0, 0, 0, 0, 4'h1, 1'b0);
    wait_cyc(25);
    #1;
    check(skew_err && !aligned, "R6", int'({skew_err, aligned}), 2);

    fire(0, MS - 1, 2, MS - 1, 4'hf, 1'b1);
    wait_cyc(30);
    #1;
    check(aligned && !skew_err, "R5", int'({aligned, skew_err}), 2);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    chk_cont = 1'b1;
    wait_cyc(10);
    chk_cont = 1'b0;

    fire(0, MS, 0, 0, 4'hf, 1'b0);
    wait_cyc(35);
    #1;
    check(skew_err && !aligned, "R6", int'({skew_err, aligned}), 2);

    fire(0, 0, 0, 0, 4'hf, 1'b1);
    wait_cyc(25);
    #1;
    check(aligned && !skew_err, "R9", int'({aligned, skew_err}), 2);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    chk_cont = 1'b1;
    wait_cyc(10);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule